// File: doc/BRIEF.md
# Byte Program-and-Verify Sequencer

This block writes an image into a one-time-programmable byte memory whose erased state is all ones. Once started, it raises two digital requests: one for the high programming supply and one for the raised core supply. It then waits for a single `supply_ok` input that reports both rails as settled. After that it walks the addresses from zero upward. For each address it fetches the target byte through a valid/ready image port. It applies timed chip-enable program pulses, with output enable held high, and reads the byte back after every pulse. It stops pulsing a byte as soon as the read-back matches. No extra pulse is added after a match.

A byte that never matches within the retry limit ends the run with a failure and reports that address. Later bytes are not touched. After the last address has been programmed, the block fetches and reads back every byte a second time, erased ones included, and compares each against the image. It reports pass only if all of them agree. All microsecond intervals come from a prescaler that takes the clock frequency in MHz as a parameter. The short output-enable access and float delays are converted from nanoseconds into whole clock cycles.

Image port rules: `img_req_valid` and `img_req_addr` stay stable until `img_req_ready` is seen high, and the port accepts the request on that edge. `img_rsp_ready` is raised only while the block waits for a response. The data is taken on the first edge where `img_rsp_valid` and `img_rsp_ready` are both high. The image source may stall either side for any number of cycles. Only one request is ever outstanding.

Top module: `otp_burn_seq`

## Requirements
- R1: `vpp_req` and `vcc_hi_req` go high on start and stay high until the finishing cycle. No program pulse begins while `supply_ok` is low, and `mem_ce_n` is never low unless both requests are high.
- R2: Every program pulse is followed by a read-back. A byte that matches is given no further pulse, and the memory ends up holding the image.
- R3: A program pulse holds `mem_ce_n` low for PULSE_US µs (PULSE_US·CLK_MHZ to PULSE_US·CLK_MHZ+2 cycles), with `mem_oe_n` high and the data bus driven.
- R4: Address and data are driven and stable at least SETUP_US µs before `mem_ce_n` falls. They stay unchanged during the pulse and for at least HOLD_US µs after it rises.
- R5: During a read-back `mem_ce_n` is high and the data bus is released. `mem_oe_n` falls no sooner than GAP_US µs after the release. `mem_oe_n` is never low while `mem_ce_n` is low or the bus is driven.
- R6: After the last address, every address is read back against the image. A mismatch ends the run with `fail` and reports that address in `fail_addr`.
- R7: A target byte equal to all ones (8'hFF for 8-bit data) receives no program pulse.
- R8: If a byte still mismatches after MAX_PULSES pulses (default 25), the run ends with `fail`, and `fail_addr` holds that address. No pulse reaches any later address.
- R9: The image port keeps `img_req_valid` and `img_req_addr` stable until accepted. The requests go 0 to the last address in order during programming, then in order again during the final check, under any stall pattern.
- R10: The end of a run shows `done` high for one cycle, with exactly one of `pass` and `fail` high and both supply requests low. `busy` then falls, and `pass`, `fail` and `fail_addr` hold until the next start.
- R11: After reset `busy`, `done`, `pass`, `fail`, both supply requests and `mem_dq_oe` are low, and `mem_ce_n` and `mem_oe_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken while idle) |
| supply_ok | input | 1 | Both requested supplies are settled |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Last run programmed and checked every byte |
| fail | output | 1 | Last run stopped on a bad byte |
| fail_addr | output | ADDR_W | Address of the bad byte |
| vpp_req | output | 1 | Request for the programming supply |
| vcc_hi_req | output | 1 | Request for the raised core supply |
| img_req_valid | output | 1 | Image fetch request valid |
| img_req_ready | input | 1 | Image source accepts the request |
| img_req_addr | output | ADDR_W | Address of the requested image byte |
| img_rsp_valid | input | 1 | Image byte valid |
| img_rsp_ready | output | 1 | Block waits for the image byte |
| img_rsp_data | input | DATA_W | Image byte |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_dout | output | DATA_W | Data driven onto the memory bus |
| mem_dq_oe | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | DATA_W | Data read from the memory bus |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |

## Verification
The memory model needs a chosen number of pulses per address before a byte takes. The main flow is tried with four image patterns, each telling a different behaviour apart:
- Every byte takes after one pulse: the basic pulse-then-verify flow and the final check.
- Bytes of all ones: the skip rule.
- One byte needs three pulses, with the image port stalled: whether retries stop exactly at the first match and request order survives back-pressure.
- One byte never takes: the retry bound and the stop before later addresses.

A separate run corrupts an already programmed byte while the last address is being programmed, so that only the final read-back can catch it. Monitors measure pulse width, setup and hold around chip enable, the gap before output enable, and any overlap of output enable with chip enable or a driven bus.

// File: rtl/otp_burn_pkg.sv
package otp_burn_pkg;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_POWER,
    SQ_FETCH,
    SQ_DECIDE,
    SQ_PSETUP,
    SQ_PULSE,
    SQ_PHOLD,
    SQ_GAP,
    SQ_VREAD,
    SQ_VREC,
    SQ_VCHECK,
    SQ_NEXT,
    SQ_FINISH
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int ns_to_cycles(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000 + 1;
  endfunction

endpackage

// File: rtl/otp_us_tick.sv
module otp_us_tick #(
  parameter int DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (cnt == TOP) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == TOP) && !clr;
endmodule

// File: rtl/otp_phase_timer.sv
module otp_phase_timer #(
  parameter int CLK_MHZ = 200,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cyc_mode,
  input  logic [CNT_W-1:0] load,
  output logic             busy
);
  logic             tick;
  logic             run;
  logic             mode;
  logic [CNT_W-1:0] remain;
  logic             step;

  otp_us_tick #(.DIV(CLK_MHZ)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start),
    .tick (tick)
  );

  assign step = mode ? 1'b1 : tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
      run    <= 1'b0;
      mode   <= 1'b0;
    end else if (start) begin
      remain <= load;
      run    <= (load != '0);
      mode   <= cyc_mode;
    end else if (run && step) begin
      remain <= remain - 1'b1;
      if (remain == CNT_W'(1)) run <= 1'b0;
    end
  end

  assign busy = run;

  // R3
  timer_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (remain != '0));
endmodule

// File: rtl/otp_img_fetch.sv
module otp_img_fetch #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] addr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              got,
  output logic [DATA_W-1:0] data
);
  logic req_q, rsp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      rsp_q <= 1'b0;
      got   <= 1'b0;
      data  <= '0;
    end else begin
      got <= 1'b0;
      if (go) begin
        req_q <= 1'b1;
      end else if (req_q && req_ready) begin
        req_q <= 1'b0;
        rsp_q <= 1'b1;
      end
      if (rsp_q && rsp_valid) begin
        rsp_q <= 1'b0;
        data  <= rsp_data;
        got   <= 1'b1;
      end
    end
  end

  assign req_valid = req_q;
  assign req_addr  = addr;
  assign rsp_ready = rsp_q;

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));
endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
  import otp_burn_pkg::*;
#(
  parameter int CLK_MHZ    = 200,
  parameter int ADDR_W     = 19,
  parameter int DATA_W     = 8,
  parameter int PULSE_US   = 100,
  parameter int SETUP_US   = 2,
  parameter int HOLD_US    = 2,
  parameter int GAP_US     = 2,
  parameter int ACCESS_NS  = 100,
  parameter int FLOAT_NS   = 130,
  parameter int MAX_PULSES = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              supply_ok,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic              vpp_req,
  output logic              vcc_hi_req,
  output logic              img_req_valid,
  input  logic              img_req_ready,
  output logic [ADDR_W-1:0] img_req_addr,
  input  logic              img_rsp_valid,
  output logic              img_rsp_ready,
  input  logic [DATA_W-1:0] img_rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_ce_n,
  output logic              mem_oe_n
);
  localparam int PULSE_CYC = PULSE_US * CLK_MHZ;
  localparam int ACC_CYC   = ns_to_cycles(ACCESS_NS, CLK_MHZ);
  localparam int FLT_CYC   = ns_to_cycles(FLOAT_NS, CLK_MHZ);
  localparam int TMR_MAX   = imax(imax(imax(PULSE_US, SETUP_US), imax(HOLD_US, GAP_US)),
                                  imax(ACC_CYC, FLT_CYC));
  localparam int TMR_W     = $clog2(TMR_MAX + 1);
  localparam int PCNT_W    = $clog2(MAX_PULSES + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [DATA_W-1:0] BLANK     = '1;

  seq_state_e        state, nxt;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] target, rd_byte;
  logic [PCNT_W-1:0] pulse_cnt;
  logic              final_pass;
  logic              pass_r, fail_r;
  logic [ADDR_W-1:0] fail_addr_r;

  logic              tmr_start, tmr_cyc, tmr_busy;
  logic [TMR_W-1:0]  tmr_load;
  logic              f_go, f_got;
  logic [DATA_W-1:0] f_data;
  logic              byte_ok, at_last, give_up;

  otp_phase_timer #(.CLK_MHZ(CLK_MHZ), .CNT_W(TMR_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .cyc_mode(tmr_cyc),
    .load    (tmr_load),
    .busy    (tmr_busy)
  );

  otp_img_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (f_go),
    .addr     (addr),
    .req_valid(img_req_valid),
    .req_ready(img_req_ready),
    .req_addr (img_req_addr),
    .rsp_valid(img_rsp_valid),
    .rsp_ready(img_rsp_ready),
    .rsp_data (img_rsp_data),
    .got      (f_got),
    .data     (f_data)
  );

  assign byte_ok = (rd_byte == target);
  assign at_last = (addr == LAST_ADDR);
  assign give_up = final_pass || (pulse_cnt == PCNT_W'(MAX_PULSES));

  always_comb begin
    nxt       = state;
    tmr_start = 1'b0;
    tmr_cyc   = 1'b0;
    tmr_load  = '0;
    f_go      = 1'b0;
    unique case (state)
      SQ_IDLE:   if (start) nxt = SQ_POWER;
      SQ_POWER:  if (supply_ok) begin nxt = SQ_FETCH; f_go = 1'b1; end
      SQ_FETCH: begin
        if (f_got) begin
          if (final_pass) begin
            nxt = SQ_GAP; tmr_start = 1'b1; tmr_load = TMR_W'(GAP_US);
          end else begin
            nxt = SQ_DECIDE;
          end
        end
      end
      SQ_DECIDE: begin
        if (target == BLANK) nxt = SQ_NEXT;
        else begin nxt = SQ_PSETUP; tmr_start = 1'b1; tmr_load = TMR_W'(SETUP_US); end
      end
      SQ_PSETUP: if (!tmr_busy && supply_ok) begin
        nxt = SQ_PULSE; tmr_start = 1'b1; tmr_load = TMR_W'(PULSE_US);
      end
      SQ_PULSE: if (!tmr_busy) begin
        nxt = SQ_PHOLD; tmr_start = 1'b1; tmr_load = TMR_W'(HOLD_US);
      end
      SQ_PHOLD: if (!tmr_busy) begin
        nxt = SQ_GAP; tmr_start = 1'b1; tmr_load = TMR_W'(GAP_US);
      end
      SQ_GAP: if (!tmr_busy) begin
        nxt = SQ_VREAD; tmr_start = 1'b1; tmr_cyc = 1'b1; tmr_load = TMR_W'(ACC_CYC);
      end
      SQ_VREAD: if (!tmr_busy) begin
        nxt = SQ_VREC; tmr_start = 1'b1; tmr_cyc = 1'b1; tmr_load = TMR_W'(FLT_CYC);
      end
      SQ_VREC:   if (!tmr_busy) nxt = SQ_VCHECK;
      SQ_VCHECK: begin
        if (byte_ok) nxt = SQ_NEXT;
        else if (give_up) nxt = SQ_FINISH;
        else begin nxt = SQ_PSETUP; tmr_start = 1'b1; tmr_load = TMR_W'(SETUP_US); end
      end
      SQ_NEXT: begin
        if (at_last && final_pass) nxt = SQ_FINISH;
        else begin nxt = SQ_FETCH; f_go = 1'b1; end
      end
      SQ_FINISH: nxt = SQ_IDLE;
      default:   nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= SQ_IDLE;
      addr        <= '0;
      target      <= '0;
      rd_byte     <= '0;
      pulse_cnt   <= '0;
      final_pass  <= 1'b0;
      pass_r      <= 1'b0;
      fail_r      <= 1'b0;
      fail_addr_r <= '0;
    end else begin
      state <= nxt;
      case (state)
        SQ_IDLE: if (start) begin
          addr       <= '0;
          final_pass <= 1'b0;
          pass_r     <= 1'b0;
          fail_r     <= 1'b0;
          fail_addr_r <= '0;
        end
        SQ_FETCH:  if (f_got) target <= f_data;
        SQ_DECIDE: pulse_cnt <= '0;
        SQ_PSETUP: if (nxt == SQ_PULSE) pulse_cnt <= pulse_cnt + 1'b1;
        SQ_VREAD:  if (!tmr_busy) rd_byte <= mem_din;
        SQ_VCHECK: if (!byte_ok && give_up) begin
          fail_r      <= 1'b1;
          fail_addr_r <= addr;
        end
        SQ_NEXT: begin
          if (at_last) begin
            if (final_pass) pass_r <= 1'b1;
            else begin final_pass <= 1'b1; addr <= '0; end
          end else begin
            addr <= addr + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign busy       = (state != SQ_IDLE);
  assign done       = (state == SQ_FINISH);
  assign pass       = pass_r;
  assign fail       = fail_r;
  assign fail_addr  = fail_addr_r;
  assign vpp_req    = (state != SQ_IDLE) && (state != SQ_FINISH);
  assign vcc_hi_req = vpp_req;
  assign mem_addr   = addr;
  assign mem_dout   = target;
  assign mem_dq_oe  = (state == SQ_PSETUP) || (state == SQ_PULSE) || (state == SQ_PHOLD);
  assign mem_ce_n   = (state != SQ_PULSE);
  assign mem_oe_n   = (state != SQ_VREAD);

  // Pulse-width observer for the checks below
  logic [31:0] ce_low_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || mem_ce_n) ce_low_cnt <= '0;
    else ce_low_cnt <= ce_low_cnt + 1'b1;
  end

  // R1
  supply_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> (vpp_req && vcc_hi_req));
  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> (ce_low_cnt >= 32'(PULSE_CYC)));
  // R4
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dout) && mem_dq_oe));
  // R5
  verify_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_ce_n && !mem_dq_oe));
  // R8
  retry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= PCNT_W'(MAX_PULSES));
  // R10
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((pass ^ fail) && !vpp_req && !vcc_hi_req));
endmodule

// File: tb/test_otp_burn_seq.sv
`timescale 1ns/100ps
module test_otp_burn_seq;
  localparam int CLK_MHZ = 4;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int PULSE_US = 20;
  localparam int N = 1 << AW;
  localparam int PCYC = PULSE_US * CLK_MHZ;
  localparam int SETUP_MIN = 2 * CLK_MHZ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic supply_ok = 1'b0;
  logic busy, done, pass, fail, vpp_req, vcc_hi_req;
  logic [AW-1:0] fail_addr, img_req_addr, mem_addr;
  logic img_req_valid, img_req_ready, img_rsp_valid, img_rsp_ready;
  logic [DW-1:0] img_rsp_data, mem_dout, mem_din;
  logic mem_dq_oe, mem_ce_n, mem_oe_n;

  always #2.5 clk = ~clk;

  otp_burn_seq #(.CLK_MHZ(CLK_MHZ), .ADDR_W(AW), .DATA_W(DW), .PULSE_US(PULSE_US)) i_otp_burn_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .supply_ok(supply_ok),
    .busy(busy), .done(done), .pass(pass), .fail(fail), .fail_addr(fail_addr),
    .vpp_req(vpp_req), .vcc_hi_req(vcc_hi_req),
    .img_req_valid(img_req_valid), .img_req_ready(img_req_ready), .img_req_addr(img_req_addr),
    .img_rsp_valid(img_rsp_valid), .img_rsp_ready(img_rsp_ready), .img_rsp_data(img_rsp_data),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dq_oe(mem_dq_oe), .mem_din(mem_din),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n));

  int tests = 0;
  int fails = 0;
  logic [DW-1:0] image [N];
  int need [N];
  logic mon_clr = 1'b0;
  logic corrupt_req = 1'b0;
  logic stall_en = 1'b0;

  // Memory model and monitors
  logic [DW-1:0] mem [N];
  int pcount [N];
  int total_pulses;
  logic prev_ce = 1'b1, prev_oe = 1'b1, prev_dq = 1'b0;
  logic [AW-1:0] prev_addr = '0;
  logic [DW-1:0] prev_dout = '0;
  int since_chg, setup_min, hold_cnt, hold_min, wcnt, wmin, wmax, viol, since_rel, gap_min;
  logic hold_arm;
  logic [AW-1:0] req_log [2*N];
  int log_n;
  logic rsp_pend;
  logic [DW-1:0] rsp_d;
  int cyc = 0;

  assign mem_din = (!mem_oe_n && mem_ce_n) ? mem[mem_addr] : '0;
  assign img_req_ready = !stall_en || (cyc % 3 == 0);
  assign img_rsp_valid = rsp_pend && (!stall_en || (cyc % 2 == 0));
  assign img_rsp_data = rsp_d;

  always @(posedge clk) begin
    logic chg;
    cyc <= cyc + 1;
    chg = (mem_addr != prev_addr) || (mem_dout != prev_dout) || (mem_dq_oe != prev_dq);
    prev_ce <= mem_ce_n; prev_oe <= mem_oe_n; prev_dq <= mem_dq_oe;
    prev_addr <= mem_addr; prev_dout <= mem_dout;
    if (mon_clr) begin
      for (int i = 0; i < N; i++) begin mem[i] <= '1; pcount[i] <= 0; end
      total_pulses <= 0; setup_min <= 1000000; hold_min <= 1000000; wmin <= 1000000;
      wmax <= 0; viol <= 0; gap_min <= 1000000; hold_arm <= 1'b0; log_n <= 0;
      rsp_pend <= 1'b0; since_chg <= 0; since_rel <= 0; wcnt <= 0; hold_cnt <= 0;
    end else begin
      if (corrupt_req) mem[0] <= mem[0] & 8'h7F;
      if (!prev_ce && mem_ce_n && mem_oe_n && mem_dq_oe && vpp_req) begin
        pcount[mem_addr] <= pcount[mem_addr] + 1;
        total_pulses <= total_pulses + 1;
        if (pcount[mem_addr] + 1 >= need[mem_addr]) mem[mem_addr] <= mem[mem_addr] & mem_dout;
      end
      since_chg <= chg ? 0 : since_chg + 1;
      if (prev_ce && !mem_ce_n && since_chg < setup_min) setup_min <= since_chg;
      if (!mem_ce_n) wcnt <= wcnt + 1;
      else if (!prev_ce) begin
        if (wcnt < wmin) wmin <= wcnt;
        if (wcnt > wmax) wmax <= wcnt;
        wcnt <= 0; hold_arm <= 1'b1; hold_cnt <= 0;
      end
      if (hold_arm) begin
        if (chg) begin hold_arm <= 1'b0; if (hold_cnt < hold_min) hold_min <= hold_cnt; end
        else hold_cnt <= hold_cnt + 1;
      end
      if (!mem_oe_n && (!mem_ce_n || mem_dq_oe)) viol <= viol + 1;
      since_rel <= mem_dq_oe ? 0 : since_rel + 1;
      if (prev_oe && !mem_oe_n && since_rel < gap_min) gap_min <= since_rel;
      if (img_req_valid && img_req_ready) begin
        rsp_pend <= 1'b1; rsp_d <= image[img_req_addr];
        if (log_n < 2*N) req_log[log_n] <= img_req_addr;
        log_n <= log_n + 1;
      end else if (img_rsp_valid && img_rsp_ready) rsp_pend <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic prep(input bit stall);
    @(negedge clk);
    stall_en = stall;
    mon_clr = 1'b1;
    @(negedge clk);
    mon_clr = 1'b0;
  endtask

  task automatic run_to_done();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic chk_order(input string tag);
    bit ok = (log_n == 2*N);
    for (int i = 0; i < 2*N; i++) if (req_log[i] != AW'(i % N)) ok = 0;
    chk(ok, tag, log_n, 2*N);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !pass && !fail, "R11 status idle", {busy, done, pass, fail}, 0);
    chk(!vpp_req && !vcc_hi_req, "R11 supply requests low", {vpp_req, vcc_hi_req}, 0);
    chk(mem_ce_n && mem_oe_n && !mem_dq_oe, "R11 memory pins idle", {mem_ce_n, mem_oe_n, mem_dq_oe}, 6);
  endtask

  task automatic t_basic();
    bit same = 1;
    int ones = 0;
    for (int i = 0; i < N; i++) begin image[i] = DW'(8'h11 * i + 8'h02); need[i] = 1; end
    prep(0);
    supply_ok = 1'b0;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (300) @(negedge clk);
    chk(total_pulses == 0, "R1 no pulse before supply_ok", total_pulses, 0);
    chk(vpp_req && vcc_hi_req && busy, "R1 requests raised while waiting", {vpp_req, vcc_hi_req, busy}, 7);
    supply_ok = 1'b1;
    while (!done) @(negedge clk);
    chk(pass && !fail, "R10 pass reported", {pass, fail}, 2);
    chk(!vpp_req && !vcc_hi_req, "R1 requests dropped at finish", {vpp_req, vcc_hi_req}, 0);
    for (int i = 0; i < N; i++) begin
      if (mem[i] != image[i]) same = 0;
      if (pcount[i] == 1) ones++;
    end
    chk(same, "R2 memory holds image", same, 1);
    chk(ones == N, "R2 one pulse per byte that takes at once", ones, N);
    chk(wmin >= PCYC && wmax <= PCYC + 2, "R3 pulse width", wmin, PCYC);
    chk(setup_min >= SETUP_MIN, "R4 setup before CE fall", setup_min, SETUP_MIN);
    chk(hold_min >= SETUP_MIN, "R4 hold after CE rise", hold_min, SETUP_MIN);
    chk(viol == 0, "R5 OE overlap", viol, 0);
    chk(gap_min >= SETUP_MIN, "R5 gap before OE fall", gap_min, SETUP_MIN);
    chk_order("R9 request order");
    @(negedge clk);
    chk(!busy, "R10 busy falls", busy, 0);
    repeat (50) @(negedge clk);
    chk(pass && !fail, "R10 result held", {pass, fail}, 2);
  endtask

  task automatic t_erased();
    for (int i = 0; i < N; i++) begin image[i] = DW'(8'h30 + i); need[i] = 1; end
    image[2] = 8'hFF; image[5] = 8'hFF;
    prep(0);
    run_to_done();
    chk(pcount[2] == 0 && pcount[5] == 0, "R7 blank bytes not pulsed", pcount[2] + pcount[5], 0);
    chk(total_pulses == N - 2, "R7 other bytes pulsed", total_pulses, N - 2);
    chk(pass, "R6 pass with blank bytes", pass, 1);
  endtask

  task automatic t_retry();
    for (int i = 0; i < N; i++) begin image[i] = DW'(8'hC3 ^ i); need[i] = 1; end
    need[3] = 3;
    prep(1);
    run_to_done();
    chk(pcount[3] == 3, "R2 retries stop at first match", pcount[3], 3);
    chk(pass && mem[3] == image[3], "R2 slow byte programmed", mem[3], image[3]);
    chk_order("R9 order under back-pressure");
  endtask

  task automatic t_fail();
    for (int i = 0; i < N; i++) begin image[i] = DW'(8'h0F + i); need[i] = 1; end
    need[4] = 1000;
    prep(0);
    run_to_done();
    chk(fail && !pass && fail_addr == 3'd4, "R8 fail address", fail_addr, 4);
    chk(pcount[4] == 25, "R8 pulse limit", pcount[4], 25);
    chk(pcount[5] + pcount[6] + pcount[7] == 0, "R8 later bytes untouched",
        pcount[5] + pcount[6] + pcount[7], 0);
    chk(!vpp_req && !vcc_hi_req, "R10 requests low after fail", {vpp_req, vcc_hi_req}, 0);
  endtask

  task automatic t_final();
    for (int i = 0; i < N; i++) begin image[i] = DW'(8'h4B + i); need[i] = 1; end
    image[0] = 8'hA5;
    prep(0);
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    while (!(mem_addr == 3'(N - 1) && !mem_ce_n)) @(negedge clk);
    corrupt_req = 1'b1; @(negedge clk); corrupt_req = 1'b0;
    while (!done) @(negedge clk);
    chk(fail && !pass && fail_addr == 3'd0, "R6 final check catches corruption", fail_addr, 0);
    chk(total_pulses == N, "R6 no pulse in final check", total_pulses, N);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    supply_ok = 1'b1;
    t_erased();
    t_retry();
    t_fail();
    t_final();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule